// File: doc/BRIEF.md
# UDP Transmit Frame Builder

This block produces complete Ethernet/IPv4/UDP frames on a 256-bit bus and writes them, one word per cycle, into a downstream show-ahead MAC FIFO. A send command carries a total byte count and a per-packet payload size. The block cuts the total into packets of that size, with a shorter final packet when the total does not divide evenly. For each packet it assembles a 42-byte header from the configured MAC, IPv4 and port values and fills in the IPv4 header checksum. It then pulls payload words from an external show-ahead FIFO read port and shifts them by ten bytes so that the payload follows the header without a gap. The UDP checksum field is sent as zero, which means the checksum is not used.

On demand the block also sends an ARP request, with a broadcast destination, or an ARP reply addressed to the peer. Both are padded to the 60-byte minimum. A frame starts only when the MAC FIFO can hold all of it and, for UDP, when the whole packet's payload is already waiting. Once a frame starts, its words go out back to back. A one-cycle `done` pulse marks the end of each command.

Top module: `udptx_frame_builder`

## Requirements
- R1: Bytes go out in network order, with byte 0 of each word on bits 255:248. A UDP frame starts with peer MAC, local MAC and EtherType 0x0800. Then comes an IPv4 header with bytes 0x45, 0x00, total length (28 + payload), identification 0, flags/offset 0, TTL 64, protocol 17, checksum, source IP and destination IP. Then comes the UDP header: source port, destination port, length (8 + payload) and checksum 0.
- R2: A frame of S words starts only in a cycle where `macWrCnt` < 65535 − S. While that does not hold, no word is written.
- R3: Once the first word of a frame is written, `macWrEn` stays high every cycle through the word that carries `macEnd`. A UDP frame with P payload bytes has P/32 + 2 words. An ARP frame has 2 words.
- R4: `macSizeWords` equals the frame length in words and stays constant for the whole frame. Its bits 15:11 are zero.
- R5: `macEnd` is high only on the final word. With it, `macLastEmpty` is 22 for UDP frames and 4 for ARP frames.
- R6: A command with total T sends packets of the programmed size in order. The last packet carries the remainder. During each frame, `remainBytes` shows the bytes left after that packet, and it is 0 after the command.
- R7: The IPv4 header checksum makes the one's-complement sum of the 20 header bytes equal 0xFFFF.
- R8: Payload byte i of a packet goes at frame byte 42 + i, taken from the FIFO words in read order. Bytes after the payload in the final word are zero. `pldRdEn` pops exactly P/32 words per packet, only while a frame is being written.
- R9: An ARP frame carries a destination MAC, local MAC, 0x0806, 0x0001, 0x0800, 6, 4, an operation code, the local MAC and source IP, a target MAC and the destination IP, followed by zeros to 60 bytes. A request has destination FF:FF:FF:FF:FF:FF, operation 1 and target MAC 0. A reply has destination and target MAC both equal to the peer MAC, and operation 2.
- R10: Bits 4:0 of `totalLen` and `pktLen` are ignored. An aligned packet size of 0 is taken as 32, and a size above 16000 is taken as 16000.
- R11: `done` pulses for one cycle in the cycle after the final word of a command's last frame. A send command whose aligned total is 0 sends no frame and still gives one `done` pulse.
- R12: After reset the block is idle: `busy`, `macWrEn`, `pldRdEn` and `done` are low. Commands that arrive while busy are ignored. When both arrive in the same idle cycle, an ARP request or reply wins over a send.
- R13: A UDP packet of P bytes starts only when `pldCount` ≥ P/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localMac | input | 48 | This node's MAC address |
| peerMac | input | 48 | Remote node's MAC address |
| srcIp | input | 32 | This node's IPv4 address |
| dstIp | input | 32 | Remote IPv4 address |
| srcPort | input | 16 | UDP source port for sending |
| dstPort | input | 16 | UDP destination port for sending |
| totalLen | input | 48 | Total bytes for a send command |
| pktLen | input | 16 | Payload bytes per packet |
| startSend | input | 1 | One-cycle send command |
| arpReq | input | 1 | One-cycle ARP request command |
| arpReply | input | 1 | One-cycle ARP reply command |
| pldData | input | 256 | Head word of the payload FIFO (show-ahead) |
| pldCount | input | 16 | Words waiting in the payload FIFO |
| pldRdEn | output | 1 | Pops the payload FIFO head |
| macWrCnt | input | 16 | Fill count of the MAC FIFO in words |
| macWrData | output | 256 | Frame word |
| macWrEn | output | 1 | Frame word valid |
| macEnd | output | 1 | Final word of the frame |
| macLastEmpty | output | 5 | Unused bytes in the final word |
| macSizeWords | output | 16 | Frame length in words |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command completion pulse |
| remainBytes | output | 48 | Bytes of the command not yet packetized |

## Verification
In the quickest case the first frame word appears two cycles after the clock edge that takes a command. The first cycle decides the start and the second emits the word. After that, each frame word and its payload pop fall in the same cycle, and `done` comes exactly one cycle after the word carrying `macEnd`. The bench drives inputs and samples every output on the falling clock edge. It follows frames word by word as they appear, instead of waiting a fixed delay. It checks `done` at exactly the sample after the final word, and it counts frames over idle gaps to show that stalled or ignored commands emit nothing.

// File: rtl/udptx_pkg.sv
package udptx_pkg;
  localparam int HDR_BYTES = 42;
  localparam int ARP_FRAME_BYTES = 60;

  typedef enum logic [1:0] {SEL_HEAD, SEL_TAIL, SEL_MID, SEL_LAST} wordSel_e;

  typedef struct packed {
    logic     latch;
    logic     isArp;
    logic     arpReply;
    wordSel_e sel;
    logic     pop;
  } txStrobe_t;
endpackage

// File: rtl/udptx_ctrl.sv
module udptx_ctrl
  import udptx_pkg::*;
#(
  parameter int LEN_W       = 48,
  parameter int CNT_W       = 16,
  parameter int BUS_BYTES   = 32,
  parameter int MAX_PAYLOAD = 16000,
  localparam int ALIGN      = $clog2(BUS_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startSend,
  input  logic             arpReq,
  input  logic             arpReply,
  input  logic [LEN_W-1:0] totalLen,
  input  logic [15:0]      pktLen,
  input  logic [CNT_W-1:0] macWrCnt,
  input  logic [CNT_W-1:0] pldCount,
  output txStrobe_t        strb,
  output logic [15:0]      curBytes,
  output logic             macWrEn,
  output logic             macEnd,
  output logic [ALIGN-1:0] macLastEmpty,
  output logic [CNT_W-1:0] macSizeWords,
  output logic             busy,
  output logic             done,
  output logic [LEN_W-1:0] remainBytes
);
  localparam int UDP_EMPTY = 2 * BUS_BYTES - HDR_BYTES;
  localparam int ARP_EMPTY = 2 * BUS_BYTES - ARP_FRAME_BYTES;
  localparam logic [15:0] LOW_MASK = 16'(BUS_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_EMIT} state_e;

  state_e           state;
  logic [LEN_W-1:0] remain;
  logic [15:0]      pktReg;
  logic [CNT_W-1:0] wordIdx, lastIdx;
  logic             isArp, arpRep, doneQ;
  logic [CNT_W-1:0] curWords, frameWords;
  logic             roomOk, pldOk, go, lastW;

  function automatic logic [15:0] clampLen(input logic [15:0] p);
    logic [15:0] a;
    a = p & ~LOW_MASK;
    if (a == 16'd0) a = 16'(BUS_BYTES);
    else if (a > 16'(MAX_PAYLOAD)) a = 16'(MAX_PAYLOAD);
    return a;
  endfunction

  always_comb begin
    curBytes   = isArp ? 16'd0 : ((remain < LEN_W'(pktReg)) ? remain[15:0] : pktReg);
    curWords   = CNT_W'(curBytes >> ALIGN);
    frameWords = isArp ? CNT_W'(2) : curWords + CNT_W'(2);
    roomOk     = macWrCnt < ({CNT_W{1'b1}} - frameWords);
    pldOk      = isArp || (pldCount >= curWords);
    go         = roomOk && pldOk && (isArp || remain != '0);
    lastW      = wordIdx == lastIdx;
  end

  always_comb begin
    strb.latch    = (state == ST_ARM) && go;
    strb.isArp    = isArp;
    strb.arpReply = arpRep;
    if (wordIdx == '0)             strb.sel = SEL_HEAD;
    else if (wordIdx == CNT_W'(1)) strb.sel = SEL_TAIL;
    else if (lastW)                strb.sel = SEL_LAST;
    else                           strb.sel = SEL_MID;
    strb.pop = (state == ST_EMIT) && !isArp && (strb.sel == SEL_TAIL || strb.sel == SEL_MID);
  end

  assign macWrEn      = state == ST_EMIT;
  assign macEnd       = macWrEn && lastW;
  assign macLastEmpty = macEnd ? (isArp ? ALIGN'(ARP_EMPTY) : ALIGN'(UDP_EMPTY)) : '0;
  assign macSizeWords = lastIdx + CNT_W'(1);
  assign busy         = state != ST_IDLE;
  assign done         = doneQ;
  assign remainBytes  = remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      pktReg  <= '0;
      wordIdx <= '0;
      lastIdx <= '0;
      isArp   <= 1'b0;
      arpRep  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (arpReq || arpReply) begin
            isArp  <= 1'b1;
            arpRep <= !arpReq;
            state  <= ST_ARM;
          end else if (startSend) begin
            isArp  <= 1'b0;
            remain <= totalLen & ~LEN_W'(BUS_BYTES - 1);
            pktReg <= clampLen(pktLen);
            state  <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (!isArp && remain == '0) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end else if (go) begin
            wordIdx <= '0;
            lastIdx <= frameWords - CNT_W'(1);
            remain  <= remain - LEN_W'(curBytes);
            state   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          wordIdx <= wordIdx + CNT_W'(1);
          if (lastW) begin
            if (isArp || remain == '0) begin
              doneQ <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_ARM;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udptx_datapath.sv
module udptx_datapath
  import udptx_pkg::*;
#(
  parameter int BUS_W = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strb,
  input  logic [15:0]      curBytes,
  input  logic [47:0]      localMac,
  input  logic [47:0]      peerMac,
  input  logic [31:0]      srcIp,
  input  logic [31:0]      dstIp,
  input  logic [15:0]      srcPort,
  input  logic [15:0]      dstPort,
  input  logic [BUS_W-1:0] pldData,
  output logic [BUS_W-1:0] macWrData
);
  localparam int HDR_W   = HDR_BYTES * 8;
  localparam int SPILL_W = HDR_W - BUS_W;
  localparam int FILL_W  = BUS_W - SPILL_W;

  logic [HDR_W-1:0]   hdrReg, hdrNext;
  logic [SPILL_W-1:0] carry;
  logic [15:0]        ipTot, udpLen;

  function automatic logic [15:0] hdrCsum(input logic [15:0] tot, input logic [31:0] s,
                                          input logic [31:0] d);
    logic [19:0] acc;
    acc = 20'h04500 + 20'h04011 + {4'b0, tot} + {4'b0, s[31:16]} + {4'b0, s[15:0]}
        + {4'b0, d[31:16]} + {4'b0, d[15:0]};
    acc = {4'b0, acc[15:0]} + {16'b0, acc[19:16]};
    acc = {4'b0, acc[15:0]} + {16'b0, acc[19:16]};
    return ~acc[15:0];
  endfunction

  always_comb begin
    ipTot  = 16'd28 + curBytes;
    udpLen = 16'd8 + curBytes;
    if (strb.isArp)
      hdrNext = {strb.arpReply ? peerMac : 48'hFFFF_FFFF_FFFF, localMac, 16'h0806,
                 16'h0001, 16'h0800, 8'd6, 8'd4, strb.arpReply ? 16'd2 : 16'd1,
                 localMac, srcIp, strb.arpReply ? peerMac : 48'h0, dstIp};
    else
      hdrNext = {peerMac, localMac, 16'h0800, 8'h45, 8'h00, ipTot, 16'h0000, 16'h0000,
                 8'd64, 8'd17, hdrCsum(ipTot, srcIp, dstIp), srcIp, dstIp,
                 srcPort, dstPort, udpLen, 16'h0000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg <= '0;
      carry  <= '0;
    end else begin
      if (strb.latch) hdrReg <= hdrNext;
      if (strb.pop)   carry  <= pldData[SPILL_W-1:0];
    end
  end

  always_comb begin
    unique case (strb.sel)
      SEL_HEAD: macWrData = hdrReg[HDR_W-1 -: BUS_W];
      SEL_TAIL: macWrData = {hdrReg[SPILL_W-1:0], strb.pop ? pldData[BUS_W-1 -: FILL_W] : FILL_W'(0)};
      SEL_MID:  macWrData = {carry, pldData[BUS_W-1 -: FILL_W]};
      default:  macWrData = {carry, FILL_W'(0)};
    endcase
  end
endmodule

// File: rtl/udptx_frame_builder.sv
module udptx_frame_builder
  import udptx_pkg::*;
#(
  parameter int BUS_W       = 256,
  parameter int LEN_W       = 48,
  parameter int CNT_W       = 16,
  parameter int MAX_PAYLOAD = 16000,
  localparam int EMPTY_W    = $clog2(BUS_W / 8)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [47:0]        localMac,
  input  logic [47:0]        peerMac,
  input  logic [31:0]        srcIp,
  input  logic [31:0]        dstIp,
  input  logic [15:0]        srcPort,
  input  logic [15:0]        dstPort,
  input  logic [LEN_W-1:0]   totalLen,
  input  logic [15:0]        pktLen,
  input  logic               startSend,
  input  logic               arpReq,
  input  logic               arpReply,
  input  logic [BUS_W-1:0]   pldData,
  input  logic [CNT_W-1:0]   pldCount,
  output logic               pldRdEn,
  input  logic [CNT_W-1:0]   macWrCnt,
  output logic [BUS_W-1:0]   macWrData,
  output logic               macWrEn,
  output logic               macEnd,
  output logic [EMPTY_W-1:0] macLastEmpty,
  output logic [CNT_W-1:0]   macSizeWords,
  output logic               busy,
  output logic               done,
  output logic [LEN_W-1:0]   remainBytes
);
  txStrobe_t   strb;
  logic [15:0] curBytes;

  udptx_ctrl #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .BUS_BYTES(BUS_W / 8), .MAX_PAYLOAD(MAX_PAYLOAD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startSend(startSend), .arpReq(arpReq), .arpReply(arpReply),
    .totalLen(totalLen), .pktLen(pktLen), .macWrCnt(macWrCnt), .pldCount(pldCount),
    .strb(strb), .curBytes(curBytes), .macWrEn(macWrEn), .macEnd(macEnd),
    .macLastEmpty(macLastEmpty), .macSizeWords(macSizeWords), .busy(busy), .done(done),
    .remainBytes(remainBytes)
  );

  udptx_datapath #(.BUS_W(BUS_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .curBytes(curBytes), .localMac(localMac),
    .peerMac(peerMac), .srcIp(srcIp), .dstIp(dstIp), .srcPort(srcPort), .dstPort(dstPort),
    .pldData(pldData), .macWrData(macWrData)
  );

  assign pldRdEn = strb.pop;
endmodule

// File: rtl/udptx_checker.sv
module udptx_checker #(
  parameter int CNT_W = 16,
  parameter int EMPTY_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               macWrEn,
  input logic               macEnd,
  input logic [EMPTY_W-1:0] macLastEmpty,
  input logic [CNT_W-1:0]   macSizeWords,
  input logic [CNT_W-1:0]   macWrCnt,
  input logic               pldRdEn,
  input logic               busy,
  input logic               done
);
  assert_room_at_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(macWrEn) |-> (macWrCnt < ({CNT_W{1'b1}} - macSizeWords)));

  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (macWrEn && !macEnd) |=> macWrEn);

  assert_size_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (macWrEn && !macEnd) |=> $stable(macSizeWords));

  assert_size_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    macWrEn |-> (macSizeWords[CNT_W-1:11] == '0));

  assert_end_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    macEnd |-> (macWrEn && (macLastEmpty == EMPTY_W'(22) || macLastEmpty == EMPTY_W'(4))));

  assert_pop_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    pldRdEn |-> macWrEn);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !macWrEn);
endmodule

bind udptx_frame_builder udptx_checker #(.CNT_W(CNT_W), .EMPTY_W(EMPTY_W)) uChk (
  .clk(clk), .rstN(rstN), .macWrEn(macWrEn), .macEnd(macEnd), .macLastEmpty(macLastEmpty),
  .macSizeWords(macSizeWords), .macWrCnt(macWrCnt), .pldRdEn(pldRdEn), .busy(busy),
  .done(done)
);

// File: tb/tb_udptx_frame_builder.sv
module tb_udptx_frame_builder;
  localparam int N_VEC = 6;
  // {totalLen, pktLen}
  localparam logic [63:0] VEC [N_VEC] = '{
    {48'd64, 16'd64}, {48'd96, 16'd32}, {48'd160, 16'd64},
    {48'd1024, 16'd1472}, {48'd200, 16'd96}, {48'd64, 16'd5}
  };
  localparam int MAXB = 16064;

  logic clk = 0, rstN = 0;
  logic [47:0] localMac = 48'h02_11_22_33_44_55, peerMac = 48'h02_AA_BB_CC_DD_EE;
  logic [31:0] srcIp = 32'hC0A8_0A01, dstIp = 32'hC0A8_0A02;
  logic [15:0] srcPort = 16'h1388, dstPort = 16'h2710;
  logic [47:0] totalLen = 0;
  logic [15:0] pktLen = 0;
  logic startSend = 0, arpReq = 0, arpReply = 0;
  logic [255:0] pldData;
  logic [15:0] pldCount, macWrCnt = 0, gateCnt = 0;
  logic gateOn = 0;
  logic pldRdEn, macWrEn, macEnd, busy, done;
  logic [255:0] macWrData;
  logic [4:0] macLastEmpty;
  logic [15:0] macSizeWords;
  logic [47:0] remainBytes;

  udptx_frame_builder dut (
    .clk(clk), .rstN(rstN), .localMac(localMac), .peerMac(peerMac), .srcIp(srcIp),
    .dstIp(dstIp), .srcPort(srcPort), .dstPort(dstPort), .totalLen(totalLen), .pktLen(pktLen),
    .startSend(startSend), .arpReq(arpReq), .arpReply(arpReply), .pldData(pldData),
    .pldCount(pldCount), .pldRdEn(pldRdEn), .macWrCnt(macWrCnt), .macWrData(macWrData),
    .macWrEn(macWrEn), .macEnd(macEnd), .macLastEmpty(macLastEmpty),
    .macSizeWords(macSizeWords), .busy(busy), .done(done), .remainBytes(remainBytes)
  );

  always #2ns clk = ~clk;

  int nChecks = 0, nFails = 0, cyc = 0;
  int rdPtr = 0;

  function automatic logic [7:0] pb(input int n);
    return 8'((n * 13 + 5) ^ (n >> 7));
  endfunction

  always_comb begin
    for (int k = 0; k < 32; k++) pldData[255 - 8 * k -: 8] = pb(rdPtr * 32 + k);
  end
  assign pldCount = gateOn ? gateCnt : 16'd4000;

  always @(posedge clk) if (rstN && pldRdEn) rdPtr <= rdPtr + 1;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog (R3 progress): actual %0d cycles expected fewer", cyc);
      finishRun();
    end
  end

  // expected-frame model
  logic [7:0] expB [MAXB];
  logic [7:0] rxB [MAXB];
  logic [47:0] expRemain = 0;
  logic [15:0] expPkt = 0;
  int pldOff = 0, frames = 0, doneCount = 0, wIdx = 0, expWords = 0, sizeAtStart = 0;
  bit inFrame = 0, expArp = 0, expArpReply = 0, doneArm = 0, lastPkt = 0, sizeBad = 0;

  task automatic putB(input int at, input logic [47:0] v, input int n);
    for (int i = 0; i < n; i++) expB[at + i] = v[8 * (n - 1 - i) +: 8];
  endtask

  task automatic buildUdp(input int nb);
    for (int i = 0; i < nb + 64; i++) expB[i] = 8'h00;
    putB(0, peerMac, 6);  putB(6, localMac, 6); putB(12, 48'h0800, 2);
    putB(14, 48'h45, 1);  putB(16, 48'(28 + nb), 2); putB(22, 48'd64, 1); putB(23, 48'd17, 1);
    putB(26, 48'(srcIp), 4); putB(30, 48'(dstIp), 4);
    putB(34, 48'(srcPort), 2); putB(36, 48'(dstPort), 2); putB(38, 48'(8 + nb), 2);
    for (int i = 0; i < nb; i++) expB[42 + i] = pb(pldOff + i);
  endtask

  task automatic buildArp(input bit rep);
    for (int i = 0; i < 64; i++) expB[i] = 8'h00;
    putB(0, rep ? peerMac : 48'hFFFF_FFFF_FFFF, 6); putB(6, localMac, 6);
    putB(12, 48'h0806, 2); putB(14, 48'h0001, 2); putB(16, 48'h0800, 2);
    putB(18, 48'd6, 1); putB(19, 48'd4, 1); putB(20, rep ? 48'd2 : 48'd1, 2);
    putB(22, localMac, 6); putB(28, 48'(srcIp), 4);
    putB(32, rep ? peerMac : 48'h0, 6); putB(38, 48'(dstIp), 4);
  endtask

  always @(negedge clk) begin
    if (doneArm) begin
      check(done === 1'b1, "R11 done one cycle after final word", done, 1);
      doneArm = 0;
    end
    if (done) doneCount++;
    if (rstN && macWrEn) begin
      if (!inFrame) begin
        inFrame = 1; wIdx = 0; sizeBad = 0; sizeAtStart = macSizeWords;
        check(macWrCnt < 16'hFFFF - macSizeWords, "R2 room at frame start", macWrCnt, 16'hFFFF - macSizeWords);
        if (expArp) begin
          buildArp(expArpReply); expWords = 2; lastPkt = 1;
        end else begin
          longint cur;
          cur = (expRemain < 48'(expPkt)) ? longint'(expRemain) : longint'(expPkt);
          expRemain = expRemain - 48'(cur);
          buildUdp(int'(cur)); pldOff += int'(cur);
          expWords = int'(cur) / 32 + 2; lastPkt = (expRemain == 0);
          check(remainBytes == expRemain, "R6 remaining bytes", remainBytes, expRemain);
        end
        check(sizeAtStart == expWords, "R4 frame size", sizeAtStart, expWords);
        check(macSizeWords[15:11] == 0, "R4 size upper bits", macSizeWords[15:11], 0);
      end
      if (macSizeWords != 16'(sizeAtStart)) sizeBad = 1;
      if (wIdx < MAXB / 32)
        for (int k = 0; k < 32; k++) rxB[wIdx * 32 + k] = macWrData[255 - 8 * k -: 8];
      if (macEnd) begin
        int bad;
        check(wIdx + 1 == expWords, "R3 words in frame", wIdx + 1, expWords);
        check(macLastEmpty == (expArp ? 5'd4 : 5'd22), "R5 end empty code", macLastEmpty, expArp ? 4 : 22);
        check(!sizeBad, "R4 size stable", macSizeWords, sizeAtStart);
        bad = -1;
        for (int i = 0; i < expWords * 32; i++)
          if (bad < 0 && !(!expArp && (i == 24 || i == 25)) && rxB[i] !== expB[i]) bad = i;
        if (bad < 0) check(1, "R1 frame bytes", 0, 0);
        else if (expArp) check(0, "R9 ARP byte", rxB[bad], expB[bad]);
        else if (bad < 42) check(0, $sformatf("R1 header byte %0d", bad), rxB[bad], expB[bad]);
        else check(0, $sformatf("R8 payload byte %0d", bad), rxB[bad], expB[bad]);
        if (!expArp) begin
          logic [31:0] s;
          s = 0;
          for (int i = 14; i < 34; i += 2) s += {16'h0, rxB[i], rxB[i + 1]};
          s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
          s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
          check(s[15:0] == 16'hFFFF, "R7 IPv4 checksum sum", s[15:0], 16'hFFFF);
        end
        inFrame = 0; frames++;
        if (lastPkt) doneArm = 1;
      end
      wIdx++;
    end else if (inFrame) begin
      check(0, "R3 gap inside frame", 0, 1);
      inFrame = 0;
    end
  end

  function automatic logic [15:0] clampB(input logic [15:0] p);
    logic [15:0] a;
    a = {p[15:5], 5'b0};
    if (a == 0) return 16'd32;
    if (a > 16'd16000) return 16'd16000;
    return a;
  endfunction

  task automatic sendCmd(input logic [47:0] tot, input logic [15:0] pkt);
    expArp = 0; expRemain = {tot[47:5], 5'b0}; expPkt = clampB(pkt);
    @(negedge clk); totalLen = tot; pktLen = pkt; startSend = 1;
    @(negedge clk); startSend = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int f0, d0;
    repeat (5) @(negedge clk);
    check(!busy && !macWrEn && !pldRdEn && !done, "R12 idle after reset",
          {busy, macWrEn, pldRdEn, done}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < N_VEC; v++) begin
      longint al, p, n;
      f0 = frames; d0 = doneCount;
      sendCmd(VEC[v][63:16], VEC[v][15:0]);
      waitIdle();
      al = longint'({VEC[v][63:21], 5'b0});
      p  = longint'(clampB(VEC[v][15:0]));
      n  = (al + p - 1) / p;
      check(frames - f0 == n, $sformatf("R6/R10 packet count vector %0d", v), frames - f0, n);
      check(doneCount - d0 == 1, "R11 one done per command", doneCount - d0, 1);
      check(remainBytes == 0, "R6 remaining zero after command", remainBytes, 0);
    end

    // R9 ARP request then reply
    for (int r = 0; r < 2; r++) begin
      f0 = frames;
      expArp = 1; expArpReply = bit'(r);
      @(negedge clk); arpReq = (r == 0); arpReply = (r == 1);
      @(negedge clk); arpReq = 0; arpReply = 0;
      waitIdle();
      check(frames - f0 == 1, "R9 one ARP frame", frames - f0, 1);
    end

    // R12 ARP wins over a simultaneous send
    f0 = frames; expArp = 1; expArpReply = 0;
    @(negedge clk); totalLen = 48'd64; pktLen = 16'd64; startSend = 1; arpReq = 1;
    @(negedge clk); startSend = 0; arpReq = 0;
    waitIdle(); repeat (10) @(negedge clk);
    check(frames - f0 == 1, "R12 ARP priority, send dropped", frames - f0, 1);

    // R12 commands ignored while busy
    f0 = frames; d0 = doneCount;
    sendCmd(48'd96, 16'd32);
    while (frames == f0) @(negedge clk);
    totalLen = 48'd3200; startSend = 1; arpReq = 1;
    @(negedge clk); startSend = 0; arpReq = 0;
    waitIdle(); repeat (20) @(negedge clk);
    check(frames - f0 == 3, "R12 commands ignored while busy", frames - f0, 3);
    check(doneCount - d0 == 1, "R12 single done while busy cmds", doneCount - d0, 1);

    // R2 room gating at the exact boundary
    f0 = frames; macWrCnt = 16'd65532;
    sendCmd(48'd32, 16'd32);
    repeat (20) @(negedge clk);
    check(frames == f0 && macWrEn == 0 && busy, "R2 held without room", frames - f0, 0);
    macWrCnt = 16'd65531;
    waitIdle();
    check(frames - f0 == 1, "R2 sent once room appears", frames - f0, 1);
    macWrCnt = 0;

    // R13 payload availability gating
    f0 = frames; gateOn = 1; gateCnt = 16'd1;
    sendCmd(48'd64, 16'd64);
    repeat (20) @(negedge clk);
    check(frames == f0 && !pldRdEn, "R13 held without payload", frames - f0, 0);
    gateCnt = 16'd2;
    waitIdle();
    check(frames - f0 == 1, "R13 sent once payload present", frames - f0, 1);
    gateOn = 0;

    // R10 oversize packet clamp
    f0 = frames;
    sendCmd(48'd16032, 16'd20000);
    waitIdle();
    check(frames - f0 == 2, "R10 clamp to 16000", frames - f0, 2);

    // R11 zero total
    f0 = frames; d0 = doneCount;
    sendCmd(48'd31, 16'd64);
    waitIdle();
    check(frames == f0, "R11 zero total sends nothing", frames - f0, 0);
    check(doneCount - d0 == 1, "R11 zero total still done", doneCount - d0, 1);

    finishRun();
  end
endmodule